// File: doc/BRIEF.md
# Dual-Track Magnetic Stripe Receiver

This block decodes two magnetic stripe tracks at once. Each track arrives as three clean digital levels: a strobe, a data line and a card-present line. All of them are brought into the system clock through two-flop synchronisers. On every rising edge of a synchronised strobe the data level is shifted in, least significant bit first. While a track is hunting, the last character-width of bits is compared against that track's start sentinel. Once the sentinel is found, every following group of bits forms one character. The character is stored, with a parity-error flag, in a small per-track buffer.

Track 1 uses 7-bit characters: 6 data bits and an odd-parity bit. Track 2 uses 5-bit characters: 4 data bits and an odd-parity bit. The stripe edges can be worn, and bits near card insertion can be corrupt. For that reason a sentinel only counts once a configurable number of strobes has passed since the card was detected. Leading zero characters pass through the hunt without effect. Removing the card drops the track back to hunting but keeps any unread characters.

A host reads each track through a pop strobe and the head-of-buffer outputs. One interrupt line is raised whenever either track has data waiting or has locked onto its sentinel.

Top module: `magstripe_dual_rx`

## Requirements
- R1: Each track takes exactly one data bit per rising edge of its strobe, seen after a two-flop synchroniser, and assembles characters least significant bit first. Track 1 characters are 7 bits, with data in bits 5..0 and odd parity in bit 6. Track 2 characters are 5 bits, with data in bits 3..0 and odd parity in bit 4.
- R2: A track locks (its `sync_o` bit goes high) when its last received bits equal its sentinel. The track 1 sentinel is 7'h45, which is data 0x05 with parity 1. The track 2 sentinel is 5'h0B, which is data 0xB with parity 0.
- R3: Zero bits and null characters received before the sentinel produce no stored character and no lock.
- R4: A sentinel is ignored when it completes on a strobe that had fewer than `GUARD_STROBES` strobes before it since card-present was last asserted.
- R5: After lock, every complete character is stored with a parity-error flag. The flag is 1 when the count of ones over the whole character, parity bit included, is even. The sentinel itself is not stored.
- R6: `rx_ready_o[t]` is high exactly while track t's buffer holds a character. The char and perr outputs show the oldest entry. A one-cycle `pop_i[t]` removes that entry.
- R7: Each buffer holds `FIFO_DEPTH` (16) characters. Characters that arrive while it is full are discarded, and the stored ones stay intact.
- R8: Deasserting card-present clears that track's lock and returns it to hunting. Characters already buffered remain readable.
- R9: `irq_o` is the registered OR of both `rx_ready_o` bits and both `sync_o` bits.
- R10: The two tracks decode at the same time and independently; traffic on one never changes the other's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trk_strobe_i | input | 2 | Per-track bit strobe (bit 0 = track 1) |
| trk_data_i | input | 2 | Per-track data level |
| trk_present_i | input | 2 | Per-track card-present level |
| pop_i | input | 2 | Per-track buffer pop, one cycle |
| t1_char_o | output | 6 | Track 1 oldest character data |
| t1_perr_o | output | 1 | Track 1 oldest character parity error |
| t2_char_o | output | 4 | Track 2 oldest character data |
| t2_perr_o | output | 1 | Track 2 oldest character parity error |
| rx_ready_o | output | 2 | Per-track buffer not empty |
| sync_o | output | 2 | Per-track sentinel locked |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench places a genuine sentinel inside the guard window, right after card detection. A design that ignored the guard would lock there and decode the following nulls as characters. A run of fifty zero bits then checks that the hunt does not treat nulls as data. The bench sweeps every track 2 data value and every track 1 data value, compares each against parity computed in the bench, and includes deliberately bad parity. Overfilling a buffer by two characters exposes a design that overwrites or wraps its write pointer. Pulling the card with data pending shows whether the lock and the buffer are cleared separately, and whether the interrupt still follows the ready flag alone. Both tracks also run concurrently, which catches crossed per-track wiring.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int TRK_N   = 2;
  localparam int T1_W    = 7;          // 6 data + odd parity
  localparam int T2_W    = 5;          // 4 data + odd parity
  localparam int MAX_W   = 7;
  localparam logic [MAX_W-1:0] T1_SENT = 7'h45;
  localparam logic [MAX_W-1:0] T2_SENT = 7'h0B;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] meta, stable;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta   <= '0;
      stable <= '0;
    end else begin
      meta   <= d_i;
      stable <= meta;
    end
  end

  assign q_o = stable;
endmodule

// File: rtl/msr_track.sv
module msr_track #(
  parameter int CW = 7,
  parameter logic [msr_pkg::MAX_W-1:0] SENTINEL = 7'h45,
  parameter int GUARD = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe_s,
  input  logic          data_s,
  input  logic          present_s,
  output logic          push_o,
  output logic [CW-1:0] entry_o,
  output logic          synced_o
);
  localparam int CNT_W = $clog2(CW);
  localparam int GW    = $clog2(GUARD + 1);

  logic            strobe_d;
  logic            rise;
  logic [CW-1:0]   shreg, shreg_next;
  logic [CW-1:0]   entry_next;
  logic [CNT_W-1:0] bitcnt;
  logic [GW-1:0]   guard_cnt;

  always_ff @(posedge clk) begin
    if (rst) strobe_d <= 1'b0;
    else     strobe_d <= strobe_s;
  end

  assign rise = strobe_s & ~strobe_d;

  always_comb begin
    shreg_next = {data_s, shreg[CW-1:1]};
    entry_next = {~(^shreg_next), shreg_next[CW-2:0]};
  end

  always_ff @(posedge clk) begin
    if (rst || !present_s) begin
      synced_o  <= 1'b0;
      guard_cnt <= '0;
      shreg     <= '0;
      bitcnt    <= '0;
      push_o    <= 1'b0;
      entry_o   <= '0;
    end else begin
      push_o <= 1'b0;
      if (rise) begin
        shreg <= shreg_next;
        if (guard_cnt != GW'(GUARD)) guard_cnt <= guard_cnt + 1'b1;
        if (!synced_o) begin
          if (shreg_next == SENTINEL[CW-1:0] && guard_cnt == GW'(GUARD)) begin
            synced_o <= 1'b1;
            bitcnt   <= '0;
          end
        end else if (bitcnt == CNT_W'(CW - 1)) begin
          bitcnt  <= '0;
          push_o  <= 1'b1;
          entry_o <= entry_next;
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end

  a_r8_clear_on_removal: assert property (@(posedge clk) disable iff (rst)
    !present_s |=> !synced_o);
  a_r4_guard_before_lock: assert property (@(posedge clk) disable iff (rst)
    $rose(synced_o) |-> guard_cnt == GW'(GUARD));
  a_r5_store_only_locked: assert property (@(posedge clk) disable iff (rst)
    push_o |-> synced_o);
endmodule

// File: rtl/msr_fifo.sv
module msr_fifo #(
  parameter int W     = 7,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] q_o,
  output logic         nonempty_o
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          full, empty, wr_ok, rd_ok;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = push_i & ~full;
  assign rd_ok = pop_i & ~empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
      count <= count + (wr_ok ? 1'b1 : 1'b0) - (rd_ok ? 1'b1 : 1'b0);
    end
  end

  assign q_o        = mem[rd_ptr];
  assign nonempty_o = ~empty;

  a_r7_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    (full && push_i && !pop_i) |=> (full && $stable(wr_ptr)));
  a_r6_pop_empty_harmless: assert property (@(posedge clk) disable iff (rst)
    (empty && pop_i && !push_i) |=> (empty && $stable(rd_ptr)));
endmodule

// File: rtl/magstripe_dual_rx.sv
module magstripe_dual_rx
  import msr_pkg::*;
#(
  parameter int FIFO_DEPTH    = 16,
  parameter int GUARD_STROBES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] trk_strobe_i,
  input  logic [1:0] trk_data_i,
  input  logic [1:0] trk_present_i,
  input  logic [1:0] pop_i,
  output logic [5:0] t1_char_o,
  output logic       t1_perr_o,
  output logic [3:0] t2_char_o,
  output logic       t2_perr_o,
  output logic [1:0] rx_ready_o,
  output logic [1:0] sync_o,
  output logic       irq_o
);
  logic [3*TRK_N-1:0] sync_in, sync_out;

  assign sync_in = {trk_present_i, trk_data_i, trk_strobe_i};

  msr_sync #(.N(3*TRK_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (sync_in),
    .q_o (sync_out)
  );

  for (genvar g = 0; g < TRK_N; g++) begin : g_trk
    localparam int CW = (g == 0) ? T1_W : T2_W;
    localparam logic [MAX_W-1:0] SENT = (g == 0) ? T1_SENT : T2_SENT;

    logic          push;
    logic [CW-1:0] entry, head;

    msr_track #(.CW(CW), .SENTINEL(SENT), .GUARD(GUARD_STROBES)) u_track (
      .clk       (clk),
      .rst       (rst),
      .strobe_s  (sync_out[g]),
      .data_s    (sync_out[TRK_N + g]),
      .present_s (sync_out[2*TRK_N + g]),
      .push_o    (push),
      .entry_o   (entry),
      .synced_o  (sync_o[g])
    );

    msr_fifo #(.W(CW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk        (clk),
      .rst        (rst),
      .push_i     (push),
      .data_i     (entry),
      .pop_i      (pop_i[g]),
      .q_o        (head),
      .nonempty_o (rx_ready_o[g])
    );

    if (g == 0) begin : g_out1
      assign t1_char_o = head[CW-2:0];
      assign t1_perr_o = head[CW-1];
    end else begin : g_out2
      assign t2_char_o = head[CW-2:0];
      assign t2_perr_o = head[CW-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= (|rx_ready_o) | (|sync_o);
  end

  a_r9_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (rx_ready_o == 2'b00 && sync_o == 2'b00) |=> !irq_o);
endmodule

// File: tb/sim_magstripe_dual_rx.sv
module sim_magstripe_dual_rx;
  localparam time CLK_P = 20ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       s1 = 0, d1 = 0, p1 = 0, s2 = 0, d2 = 0, p2 = 0;
  logic [1:0] pop = 2'b00;
  logic [5:0] t1_char;
  logic       t1_perr;
  logic [3:0] t2_char;
  logic       t2_perr;
  logic [1:0] rdy, syn;
  logic       irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  magstripe_dual_rx u0 (
    .clk(clk), .rst(rst),
    .trk_strobe_i({s2, s1}), .trk_data_i({d2, d1}), .trk_present_i({p2, p1}),
    .pop_i(pop),
    .t1_char_o(t1_char), .t1_perr_o(t1_perr),
    .t2_char_o(t2_char), .t2_perr_o(t2_perr),
    .rx_ready_o(rdy), .sync_o(syn), .irq_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_bit(input int t, input bit b);
    if (t == 0) d1 = b; else d2 = b;
    repeat (2) @(negedge clk);
    if (t == 0) s1 = 1; else s2 = 1;
    repeat (3) @(negedge clk);
    if (t == 0) s1 = 0; else s2 = 0;
    repeat (2) @(negedge clk);
  endtask

  // w = full character width; parity makes the ones count odd unless bad
  task automatic send_char(input int t, input int d, input int w, input bit bad);
    int v;
    bit par;
    par = (($countones(d) % 2) == 0) ^ bad;
    v = d | (int'(par) << (w - 1));
    for (int i = 0; i < w; i++) send_bit(t, v[i]);
  endtask

  task automatic send_nulls(input int t, input int w, input int n);
    for (int i = 0; i < n * w; i++) send_bit(t, 1'b0);
  endtask

  task automatic pop_chk(input int t, input int exp_d, input int exp_p, input string tag);
    @(negedge clk);
    if (t == 0) begin
      chk({tag, " t1 data"}, t1_char, exp_d);
      chk({tag, " t1 perr"}, t1_perr, exp_p);
    end else begin
      chk({tag, " t2 data"}, t2_char, exp_d);
      chk({tag, " t2 perr"}, t2_perr, exp_p);
    end
    pop[t] = 1'b1;
    @(negedge clk);
    pop[t] = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    chk("R6 reset ready", rdy, 0);
    chk("R2 reset sync", syn, 0);
    chk("R9 reset irq", irq, 0);

    // Track 2: sentinel inside the guard window must be ignored (R4)
    p2 = 1;
    repeat (6) @(negedge clk);
    send_char(1, 11, 5, 0);
    repeat (6) @(negedge clk);
    chk("R4 early sentinel ignored", syn[1], 0);
    send_nulls(1, 5, 10);
    chk("R3 nulls no lock", syn[1], 0);
    chk("R3 nulls no data", rdy[1], 0);
    send_char(1, 11, 5, 0);
    repeat (6) @(negedge clk);
    chk("R2 t2 lock", syn[1], 1);
    chk("R5 sentinel not stored", rdy[1], 0);
    chk("R9 irq on sync", irq, 1);
    chk("R10 t1 untouched", syn[0], 0);

    // Sweep all track-2 values, then overfill by two (R7)
    for (int d = 0; d < 16; d++) send_char(1, d, 5, 0);
    send_char(1, 9, 5, 1);
    send_char(1, 10, 5, 0);
    repeat (6) @(negedge clk);
    chk("R6 ready after store", rdy[1], 1);
    for (int d = 0; d < 16; d++) pop_chk(1, d, 0, "R7 R1 sweep");
    repeat (2) @(negedge clk);
    chk("R7 overflow dropped", rdy[1], 0);

    // Bad parity, then card removal with data pending (R5, R8)
    send_char(1, 5, 5, 1);
    repeat (6) @(negedge clk);
    p2 = 0;
    repeat (6) @(negedge clk);
    chk("R8 lock cleared", syn[1], 0);
    chk("R8 data kept", rdy[1], 1);
    chk("R9 irq on ready", irq, 1);
    pop_chk(1, 5, 1, "R5 bad parity");
    repeat (3) @(negedge clk);
    chk("R6 empty after pop", rdy[1], 0);
    chk("R9 irq quiet", irq, 0);

    // Both tracks concurrently (R10), track 1 first batch
    p1 = 1; p2 = 1;
    repeat (6) @(negedge clk);
    fork
      begin
        send_nulls(0, 7, 10);
        send_char(0, 5, 7, 0);
        for (int d = 0; d < 16; d++) send_char(0, d, 7, 0);
      end
      begin
        send_nulls(1, 5, 10);
        send_char(1, 11, 5, 0);
        send_char(1, 3, 5, 0);
        send_char(1, 12, 5, 1);
      end
    join
    repeat (6) @(negedge clk);
    chk("R10 t1 lock", syn[0], 1);
    chk("R10 t2 relock", syn[1], 1);
    pop_chk(1, 3, 0, "R10");
    pop_chk(1, 12, 1, "R10");
    for (int d = 0; d < 16; d++) pop_chk(0, d, 0, "R10 R1");

    // Remaining track-1 values, including bad parity on every fourth
    for (int b = 1; b < 4; b++) begin
      for (int i = 0; i < 16; i++) send_char(0, b * 16 + i, 7, (i % 4) == 3);
      repeat (6) @(negedge clk);
      for (int i = 0; i < 16; i++) pop_chk(0, b * 16 + i, (i % 4) == 3, "R1 R5 t1 sweep");
    end
    repeat (2) @(negedge clk);
    chk("R6 t1 drained", rdy[0], 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule